// File: doc/BRIEF.md
# Low-power PWM and single-pulse timer

This block is a 16-bit up-counter that advances on ticks from a power-of-two prescaler and drives one waveform pin. An auto-reload value sets the period and a compare value sets the duty. In continuous mode the counter wraps and the pin carries a repeating PWM signal. In single-start mode the counter runs through one period, then stops and holds. A wave-mode input decides how the pin ends after that single period: it either goes back to its starting level (one-pulse) or stays at the active level (set-once). A polarity input inverts the pin.

Three sticky event flags feed one masked interrupt line: the count has reached or passed the compare value, the count equals the auto-reload value, and a filtered external trigger edge has been seen. Software can clear the counter in two ways. The first is a request that takes effect after a three-cycle synchronization delay. The second is an option that clears the counter right after each count read.

A four-state machine controls the counter. The states are ST_IDLE (stopped, count 0), ST_RUN_CONT (continuous counting), ST_RUN_SINGLE (one period) and ST_DONE (single period finished, holding). The transitions are:
- ST_IDLE or ST_DONE to ST_RUN_CONT on a continuous start.
- ST_IDLE or ST_DONE to ST_RUN_SINGLE on a single start. A continuous start has priority when both starts are present.
- ST_RUN_SINGLE to ST_DONE on the tick taken at the auto-reload value.
- Any state to ST_IDLE when `enable` is low.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset the count is 0. `flags` is 0, `irq` is 0, and `wave_out` equals `out_pol`.
- R2: With psc_sel=0, a continuous start gives a count of 0 on the first edge. The count then goes up by one each cycle up to `arr_val`, and after that wraps to 0. While running, the raw output is active exactly when count > `cmp_val`.
- R3: The counter advances once every 2^`psc_sel` cycles. With psc_sel=2 the first advance happens on the 4th edge after the start edge.
- R4: With wave_mode=0 (one-pulse), a single start counts 0 to `arr_val` once. The machine then enters ST_DONE, the count holds at `arr_val`, and the raw output is inactive.
- R5: With wave_mode=1 (set-once), the raw output stays active in ST_DONE after the single period.
- R6: `wave_out` = raw output XOR `out_pol`, so out_pol=1 inverts the waveform.
- R7: Flag bit 0 is the compare flag. It is set in any cycle where the machine is running and count >= `cmp_val`, and this includes equality. Flag bit 1 is the reload flag. It is set when the machine is running and count == `arr_val`.
- R8: Flags are sticky. A 1 in bit i of `flag_clr` clears flag i, and a set in the same cycle wins over the clear. `irq` is the OR of `flags & irq_mask`.
- R9: A `cnt_rst_req` sampled on edge k clears the count on edge k+3. The counter keeps counting on edges k+1 and k+2.
- R10: When `rst_on_rd`=1, a `cnt_rd` pulse clears the count on the next edge. When `rst_on_rd`=0, `cnt_rd` has no effect.
- R11: Flag bit 2 is the trigger flag. `trig_in` is synchronized, then filtered so that a level counts only once it has been stable for 3 cycles. The flag sets within 8 cycles of a filtered rising edge when trig_pol=0, or of a falling edge when trig_pol=1. A 1-cycle glitch does not set it.
- R12: With `enable` low the machine is in ST_IDLE, with the count at 0 and the raw output inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Timer enable; low forces ST_IDLE |
| cont_start | input | 1 | Pulse: start continuous counting |
| single_start | input | 1 | Pulse: start one period |
| wave_mode | input | 1 | 0 one-pulse, 1 set-once |
| out_pol | input | 1 | 1 inverts wave_out |
| psc_sel | input | 3 | Prescaler divide exponent |
| arr_val | input | 16 | Auto-reload (period) value |
| cmp_val | input | 16 | Compare (duty) value |
| cnt_rst_req | input | 1 | Pulse: delayed counter clear |
| rst_on_rd | input | 1 | Enable clear-after-read |
| cnt_rd | input | 1 | Pulse: count is being read |
| trig_in | input | 1 | External trigger |
| trig_pol | input | 1 | 0 rising, 1 falling edge |
| flag_clr | input | 3 | Per-flag clear pulses |
| irq_mask | input | 3 | Per-flag interrupt enable |
| cnt_q | output | 16 | Current count |
| flags | output | 3 | Sticky flags {trig, reload, compare} |
| irq | output | 1 | Masked interrupt |
| wave_out | output | 1 | Waveform pin |

## Verification
A wrong state or a miscounted value in the machine shows on `wave_out` during the same cycle. A pin level compared against the model on every cycle therefore catches it within one period of `arr_val`+1 ticks. A delay stage that is wrong in the reset synchronizer or the trigger filter moves the visible clear or flag by a cycle, so the bench samples the count and flags on exact edges. A flag that fails to stay set, or is set in error, shows on `flags` and `irq` at the next sample taken after the run stops.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN_CONT,
        ST_RUN_SINGLE,
        ST_DONE
    } lpt_state_e;

    localparam int unsigned FLAG_CMP  = 0;
    localparam int unsigned FLAG_ARR  = 1;
    localparam int unsigned FLAG_TRIG = 2;
    localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << sel);
    assign tick = ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (clr)    pre_q <= '0;
        else if (run)    pre_q <= pre_q + 1'b1;
        else             pre_q <= '0;
    end
endmodule

// File: rtl/lpt_trig_filter.sv
module lpt_trig_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic trig_pol,
    output logic trig_ev
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] shift_q;
    logic                filt_q;
    logic                filt_d1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '0;
            shift_q   <= '0;
            filt_q    <= 1'b0;
            filt_d1_q <= 1'b0;
        end else begin
            sync_q    <= {sync_q[0], trig_in};
            shift_q   <= {shift_q[FILT_LEN-2:0], sync_q[1]};
            filt_d1_q <= filt_q;
            if (&shift_q)       filt_q <= 1'b1;
            else if (~|shift_q) filt_q <= 1'b0;
        end
    end

    assign trig_ev = trig_pol ? (filt_d1_q & ~filt_q) : (~filt_d1_q & filt_q);

    assert_ev_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ev && $stable(trig_pol)) |=> !trig_ev);
endmodule

// File: rtl/lpt_flags.sv
module lpt_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q[i] <= 1'b0;
            else if (set[i]) flag_q[i] <= 1'b1;
            else if (clr[i]) flag_q[i] <= 1'b0;
        end

        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr[i]) |=> flag_q[i]);
    end

    assign flags = flag_q;
    assign irq   = |(flag_q & mask);
endmodule

// File: rtl/lpt_core.sv
module lpt_core
    import lpt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SYNC_DLY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cont_start,
    input  logic             single_start,
    input  logic             wave_mode,
    input  logic             out_pol,
    input  logic [CNT_W-1:0] arr_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_rst_req,
    input  logic             rd_clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wave_out,
    output logic             cmp_hit,
    output logic             arr_hit,
    output logic             psc_clr,
    output logic             psc_run
);
    lpt_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_d;
    logic [SYNC_DLY-1:0] rst_sync_q;
    logic                go_cont, go_single, running, raw;

    assign go_cont   = enable & cont_start;
    assign go_single = enable & single_start & ~cont_start;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        psc_clr = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (state_q == ST_IDLE) cnt_d = '0;
                if (go_cont) begin
                    state_d = ST_RUN_CONT;
                    cnt_d   = '0;
                    psc_clr = 1'b1;
                end else if (go_single) begin
                    state_d = ST_RUN_SINGLE;
                    cnt_d   = '0;
                    psc_clr = 1'b1;
                end
            end
            ST_RUN_CONT: begin
                if (tick) cnt_d = (cnt_q == arr_val) ? '0 : cnt_q + 1'b1;
            end
            ST_RUN_SINGLE: begin
                if (tick) begin
                    if (cnt_q == arr_val) state_d = ST_DONE;
                    else                  cnt_d   = cnt_q + 1'b1;
                end
            end
        endcase
        if (rst_sync_q[SYNC_DLY-1] || rd_clr) cnt_d = '0;
        if (!enable) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            rst_sync_q <= '0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            rst_sync_q <= {rst_sync_q[SYNC_DLY-2:0], cnt_rst_req};
        end
    end

    always_comb begin
        running = (state_q == ST_RUN_CONT) || (state_q == ST_RUN_SINGLE);
        unique case (state_q)
            ST_IDLE:                  raw = 1'b0;
            ST_RUN_CONT, ST_RUN_SINGLE: raw = (cnt_q > cmp_val);
            ST_DONE:                  raw = wave_mode;
        endcase
        wave_out = raw ^ out_pol;
        cmp_hit  = running && (cnt_q >= cmp_val);
        arr_hit  = running && (cnt_q == arr_val);
        psc_run  = running;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_CONT && tick && cnt_q == arr_val && enable)
        |=> (cnt_q == '0));

    assert_swrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sync_q[SYNC_DLY-1] |=> (cnt_q == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && enable && !cont_start && !single_start &&
         !rst_sync_q[SYNC_DLY-1] && !rd_clr) |=> (cnt_q == $past(cnt_q)));

    assert_setonce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) == ST_DONE &&
         $stable(wave_mode) && $stable(out_pol)) |-> $stable(wave_out));
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer
    import lpt_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned PSC_W    = 3,
    parameter int unsigned FILT_LEN = 3,
    parameter int unsigned SYNC_DLY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 cont_start,
    input  logic                 single_start,
    input  logic                 wave_mode,
    input  logic                 out_pol,
    input  logic [PSC_W-1:0]     psc_sel,
    input  logic [CNT_W-1:0]     arr_val,
    input  logic [CNT_W-1:0]     cmp_val,
    input  logic                 cnt_rst_req,
    input  logic                 rst_on_rd,
    input  logic                 cnt_rd,
    input  logic                 trig_in,
    input  logic                 trig_pol,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    output logic [CNT_W-1:0]     cnt_q,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq,
    output logic                 wave_out
);
    logic tick, psc_clr, psc_run, cmp_hit, arr_hit, trig_ev;
    logic [NUM_FLAGS-1:0] flag_set;

    lpt_prescaler #(.SEL_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(psc_clr), .run(psc_run),
        .sel(psc_sel), .tick(tick)
    );

    lpt_core #(.CNT_W(CNT_W), .SYNC_DLY(SYNC_DLY)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cont_start(cont_start),
        .single_start(single_start), .wave_mode(wave_mode), .out_pol(out_pol),
        .arr_val(arr_val), .cmp_val(cmp_val), .cnt_rst_req(cnt_rst_req),
        .rd_clr(cnt_rd & rst_on_rd), .tick(tick), .cnt_q(cnt_q),
        .wave_out(wave_out), .cmp_hit(cmp_hit), .arr_hit(arr_hit),
        .psc_clr(psc_clr), .psc_run(psc_run)
    );

    lpt_trig_filter #(.FILT_LEN(FILT_LEN)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_pol(trig_pol),
        .trig_ev(trig_ev)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_CMP]  = cmp_hit;
        flag_set[FLAG_ARR]  = arr_hit;
        flag_set[FLAG_TRIG] = trig_ev;
    end

    lpt_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
        .mask(irq_mask), .flags(flags), .irq(irq)
    );
endmodule

// File: tb/lp_pwm_timer_tb.sv
`timescale 1ns/1ps
module lp_pwm_timer_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        enable = 0, cont_start = 0, single_start = 0;
    logic        wave_mode = 0, out_pol = 0;
    logic [2:0]  psc_sel = 0;
    logic [15:0] arr_val = 0, cmp_val = 0;
    logic        cnt_rst_req = 0, rst_on_rd = 0, cnt_rd = 0;
    logic        trig_in = 0, trig_pol = 0;
    logic [2:0]  flag_clr = 0, irq_mask = 0;
    logic [15:0] cnt_q;
    logic [2:0]  flags;
    logic        irq, wave_out;

    int n_chk = 0, n_err = 0;
    bit exp_q[$];
    bit mon_on = 0;
    string mon_req = "";

    always #2 clk = ~clk;

    lp_pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cont_start(cont_start),
        .single_start(single_start), .wave_mode(wave_mode), .out_pol(out_pol),
        .psc_sel(psc_sel), .arr_val(arr_val), .cmp_val(cmp_val),
        .cnt_rst_req(cnt_rst_req), .rst_on_rd(rst_on_rd), .cnt_rd(cnt_rd),
        .trig_in(trig_in), .trig_pol(trig_pol), .flag_clr(flag_clr),
        .irq_mask(irq_mask), .cnt_q(cnt_q), .flags(flags), .irq(irq),
        .wave_out(wave_out)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops one expected pin level per cycle, just after each edge
    always @(posedge clk) begin
        #1;
        if (mon_on && exp_q.size() > 0) chk(mon_req, int'(wave_out), int'(exp_q.pop_front()));
    end

    task automatic stop_timer();
        @(negedge clk); enable = 0;
        @(negedge clk);
    endtask

    // driver: pushes the modelled pin levels, then starts the timer
    task automatic run_stream(string req, bit cont, int arr, int cmp, bit wm, bit pol, int n);
        stop_timer();
        arr_val = 16'(arr); cmp_val = 16'(cmp); wave_mode = wm; out_pol = pol;
        psc_sel = 0;
        for (int k = 0; k < n; k++) begin
            bit raw;
            if (cont) raw = ((k % (arr + 1)) > cmp);
            else if (k <= arr) raw = (k > cmp);
            else raw = wm;
            exp_q.push_back(raw ^ pol);
        end
        mon_req = req;
        enable = 1;
        if (cont) cont_start = 1; else single_start = 1;
        mon_on = 1;
        @(negedge clk); cont_start = 0; single_start = 0;
        wait (exp_q.size() == 0);
        @(negedge clk); mon_on = 0;
    endtask

    task automatic start_run(bit cont, int arr, int cmp, int sel);
        stop_timer();
        arr_val = 16'(arr); cmp_val = 16'(cmp); psc_sel = 3'(sel);
        enable = 1;
        if (cont) cont_start = 1; else single_start = 1;
        @(negedge clk); cont_start = 0; single_start = 0;
    endtask

    task automatic clear_flags(logic [2:0] which);
        @(negedge clk); flag_clr = which;
        @(negedge clk); flag_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 cnt", int'(cnt_q), 0);
        chk("R1 flags", int'(flags), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 wave", int'(wave_out), 0);

        run_stream("R2 continuous pwm", 1, 5, 2, 0, 0, 14);
        chk("R7 cmp flag set", int'(flags[0]), 1);
        chk("R7 arr flag set", int'(flags[1]), 1);
        stop_timer();
        chk("R12 idle cnt", int'(cnt_q), 0);
        chk("R12 idle wave", int'(wave_out), 0);
        clear_flags(3'b011);
        chk("R8 flags cleared", int'(flags), 0);

        run_stream("R4 one-pulse", 0, 5, 2, 0, 0, 10);
        chk("R4 count holds at reload", int'(cnt_q), 5);
        run_stream("R5 set-once", 0, 5, 2, 1, 0, 10);
        run_stream("R6 inverted pwm", 1, 3, 0, 0, 1, 9);
        out_pol = 0;

        stop_timer(); clear_flags(3'b011);
        run_stream("R4 one-pulse cmp above reload", 0, 5, 10, 0, 0, 8);
        chk("R7 cmp flag not set when cnt below cmp", int'(flags[0]), 0);
        chk("R7 arr flag set", int'(flags[1]), 1);
        stop_timer(); clear_flags(3'b011);
        run_stream("R7 cmp equal reload wave low", 0, 5, 5, 0, 0, 8);
        chk("R7 cmp flag on equality", int'(flags[0]), 1);
        stop_timer();
        @(negedge clk); irq_mask = 3'b100;
        @(negedge clk); chk("R8 irq masked", int'(irq), 0);
        irq_mask = 3'b001;
        @(negedge clk); chk("R8 irq unmasked", int'(irq), 1);
        irq_mask = 0;

        start_run(1, 1000, 1000, 2);
        repeat (3) @(negedge clk);
        chk("R3 no advance before 4th edge", int'(cnt_q), 0);
        @(negedge clk); chk("R3 first advance", int'(cnt_q), 1);
        repeat (4) @(negedge clk); chk("R3 second advance", int'(cnt_q), 2);

        start_run(1, 1000, 1000, 0);
        repeat (5) @(negedge clk);
        v = int'(cnt_q);
        cnt_rst_req = 1;
        @(negedge clk); cnt_rst_req = 0;
        repeat (2) @(negedge clk);
        chk("R9 still counting before delay", int'(cnt_q), v + 3);
        @(negedge clk); chk("R9 cleared on third edge", int'(cnt_q), 0);
        @(negedge clk); chk("R9 counting resumes", int'(cnt_q), 1);

        repeat (4) @(negedge clk);
        rst_on_rd = 1; cnt_rd = 1;
        @(negedge clk); cnt_rd = 0;
        chk("R10 clear after read", int'(cnt_q), 0);
        repeat (3) @(negedge clk);
        rst_on_rd = 0; v = int'(cnt_q); cnt_rd = 1;
        @(negedge clk); cnt_rd = 0;
        chk("R10 read ignored when disabled", int'(cnt_q), v + 1);
        stop_timer();

        trig_pol = 0;
        @(negedge clk); trig_in = 1;
        @(negedge clk); trig_in = 0;
        repeat (12) @(negedge clk);
        chk("R11 glitch ignored", int'(flags[2]), 0);
        trig_in = 1;
        repeat (8) @(negedge clk);
        chk("R11 rising edge flag", int'(flags[2]), 1);
        repeat (4) @(negedge clk);
        clear_flags(3'b100);
        trig_pol = 1;
        repeat (4) @(negedge clk);
        chk("R11 no flag without falling edge", int'(flags[2]), 0);
        trig_in = 0;
        repeat (8) @(negedge clk);
        chk("R11 falling edge flag", int'(flags[2]), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule